// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous dual-port memory. It keeps three registers of equal width. The burst counter drives the memory address. The mask register selects which counter bits may count. The mirror register holds the last loaded start address, and the counter returns to it when a burst wraps. Bits whose mask bit is clear stay fixed and act as a base address. Bits whose mask bit is set form a counting field, and carries jump over the fixed bits.

Four active-low or select inputs choose the operation for each clock: load, reset, increment, hold or readback, applied to either the counter or the mask. A master reset overrides all of them. A readback puts the selected register on a registered output one clock later. In the cycle of the request, a disable output tells the port to release its data bus. An active-low flag goes low when an increment leaves the counting field all ones. The next increment then reloads the start address.

Top module: `masked_burst_addr_gen`

## Requirements
- R1: While `mrst_n` is low at a clock edge, the next state is counter = 0, mirror = 0, mask = all ones, `wrap_n` = 1 and `rb_valid` = 0, whatever the other controls are.
- R2: Counter load (`sel_cnt`=1, `crst_n`=1, `strobe_n`=0, `cnten_n`=0) writes `addr_in` into the counter and the mirror. `addr_out` shows the value after the edge.
- R3: Counter reset (`sel_cnt`=1, `crst_n`=0) clears the counter bits whose mask bit is 1 and keeps the others. The mirror takes the resulting value.
- R4: Increment (`sel_cnt`=1, `crst_n`=1, `strobe_n`=1, `cnten_n`=0) changes only counter bits whose mask bit is 1. The unmasked field advances by one, so the address steps by 1 when bit 0 is unmasked and by 2 when bit 0 is masked, with carries skipping masked positions.
- R5: After an increment, `wrap_n` is 0 if every unmasked counter bit is 1, and 1 otherwise.
- R6: An increment that starts from an all-ones unmasked field loads the counter from the mirror.
- R7: Counter load, counter reset, mask load and mask reset each set `wrap_n` to 1.
- R8: Counter hold (`sel_cnt`=1, `crst_n`=1, `strobe_n`=1, `cnten_n`=1) and the reserved mask codes (`sel_cnt`=0, `crst_n`=1, `strobe_n`=1) leave counter, mask, mirror and `wrap_n` unchanged.
- R9: Mask reset (`sel_cnt`=0, `crst_n`=0) sets the mask to all ones. Mask load (`sel_cnt`=0, `crst_n`=1, `strobe_n`=0, `cnten_n`=0) writes `addr_in` into the mask.
- R10: Readback (`crst_n`=1, `strobe_n`=0, `cnten_n`=1) gives `rb_valid`=1 one cycle later. `rb_data` then holds the counter when `sel_cnt`=1 and the mask when `sel_cnt`=0. `dq_off` is 1 combinationally during the request cycle and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| sel_cnt | input | 1 | 1 selects counter operations, 0 selects mask operations |
| crst_n | input | 1 | Active-low reset of the selected register |
| strobe_n | input | 1 | Active-low address strobe |
| cnten_n | input | 1 | Active-low count enable |
| addr_in | input | AW | External address or mask value |
| addr_out | output | AW | Current counter value, the memory address |
| rb_data | output | AW | Registered readback value |
| rb_valid | output | 1 | rb_data holds a readback result |
| dq_off | output | 1 | Data bus must be released (readback request) |
| wrap_n | output | 1 | Active-low flag: unmasked field is all ones |

## Verification
The counting field is tried in three shapes, each against a reference model that counts the field as a packed integer:
- A low contiguous field of six bits under a fixed base. This separates correct wrap-to-mirror from wrap-to-zero, and shows that the flag falls exactly at the all-ones point.
- A field with bit 0 masked. This shows the step of two and that bit 0 is preserved.
- A split field with holes, plus an empty field. These show whether carries skip the fixed bits rather than corrupt them.

Pseudo-random sequences over all control codes then compare the model with the outputs every cycle. These sequences include flag release by each clearing operation, reserved codes and master reset under active controls.

// File: rtl/mbc_pkg.sv
// Shared operation codes for the masked burst address counter.
// Assumes: one operation per clock, master reset handled outside the decode.
package mbc_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLOAD = 3'd1,
        OP_CCLR  = 3'd2,
        OP_CINC  = 3'd3,
        OP_CRB   = 3'd4,
        OP_MLOAD = 3'd5,
        OP_MSET  = 3'd6,
        OP_MRB   = 3'd7
    } mbc_op_e;
endpackage

// File: rtl/mbc_decode.sv
// Control decoder: maps select, reset, strobe and enable to one operation.
// Assumes: active-low controls; reserved mask codes map to hold.
module mbc_decode
    import mbc_pkg::*;
(
    input  logic    sel_cnt,
    input  logic    crst_n,
    input  logic    strobe_n,
    input  logic    cnten_n,
    output mbc_op_e op
);
    // Purpose: pure truth-table decode of the four control lines.
    always_comb begin
        op = OP_HOLD;
        if (sel_cnt) begin
            if (!crst_n)                    op = OP_CCLR;
            else if (!strobe_n && !cnten_n) op = OP_CLOAD;
            else if (!strobe_n)             op = OP_CRB;
            else if (!cnten_n)              op = OP_CINC;
        end else begin
            if (!crst_n)                    op = OP_MSET;
            else if (!strobe_n && !cnten_n) op = OP_MLOAD;
            else if (!strobe_n)             op = OP_MRB;
        end
    end
endmodule

// File: rtl/mbc_incr.sv
// Next-increment logic: advances the unmasked field by one, carries
// skipping masked bits, or returns to the mirror on an all-ones field.
// Assumes: mask bit 1 means the counter bit takes part in counting.
module mbc_incr #(
    parameter int AW = 18
) (
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] mirror,
    output logic [AW-1:0] nxt,
    output logic          nxt_full
);
    logic [AW-1:0] filled;
    logic [AW-1:0] summed;
    logic [AW-1:0] stepped;
    logic [AW-1:0] step;
    logic          at_top;

    // Purpose: fill masked holes so the carry ripples across them.
    always_comb begin
        step    = mask[0] ? AW'(1) : AW'(2);
        filled  = cnt | ~mask;
        summed  = filled + step;
        at_top  = ((cnt & mask) == mask);
        stepped = (summed & mask) | (cnt & ~mask);
        nxt     = at_top ? mirror : stepped;
        nxt_full = ((nxt & mask) == mask);
    end
endmodule

// File: rtl/mbc_readback.sv
// Readback stage: registers the selected register for output one clock
// after the request and drives the bus-release signal in the request cycle.
// Assumes: synchronous active-low reset.
module mbc_readback
    import mbc_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mbc_op_e       op,
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] rb_data,
    output logic          rb_valid,
    output logic          dq_off
);
    logic req;

    // Purpose: flag a readback request of either register.
    always_comb req = rst_n && (op == OP_CRB || op == OP_MRB);

    assign dq_off = req;

    // Purpose: pipeline the selected value to the readback output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_valid <= 1'b0;
            rb_data  <= '0;
        end else begin
            rb_valid <= req;
            rb_data  <= (op == OP_MRB) ? mask : (req ? cnt : '0);
        end
    end
endmodule

// File: rtl/masked_burst_addr_gen.sv
// Top: per-port masked burst address counter with mask and mirror registers.
// Assumes: mrst_n is a synchronous active-low master reset overriding all.
module masked_burst_addr_gen
    import mbc_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          sel_cnt,
    input  logic          crst_n,
    input  logic          strobe_n,
    input  logic          cnten_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic [AW-1:0] rb_data,
    output logic          rb_valid,
    output logic          dq_off,
    output logic          wrap_n
);
    mbc_op_e       op;
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] mask_q;
    logic [AW-1:0] mirror_q;
    logic [AW-1:0] inc_nxt;
    logic          inc_full;
    logic          wrap_q;

    mbc_decode u_dec (
        .sel_cnt (sel_cnt),
        .crst_n  (crst_n),
        .strobe_n(strobe_n),
        .cnten_n (cnten_n),
        .op      (op)
    );

    mbc_incr #(.AW(AW)) u_inc (
        .cnt     (cnt_q),
        .mask    (mask_q),
        .mirror  (mirror_q),
        .nxt     (inc_nxt),
        .nxt_full(inc_full)
    );

    mbc_readback #(.AW(AW)) u_rb (
        .clk     (clk),
        .rst_n   (mrst_n),
        .op      (op),
        .cnt     (cnt_q),
        .mask    (mask_q),
        .rb_data (rb_data),
        .rb_valid(rb_valid),
        .dq_off  (dq_off)
    );

    // Purpose: update counter, mirror, mask and flag per decoded operation.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cnt_q    <= '0;
            mirror_q <= '0;
            mask_q   <= '1;
            wrap_q   <= 1'b1;
        end else begin
            unique case (op)
                OP_CLOAD: begin
                    cnt_q    <= addr_in;
                    mirror_q <= addr_in;
                    wrap_q   <= 1'b1;
                end
                OP_CCLR: begin
                    cnt_q    <= cnt_q & ~mask_q;
                    mirror_q <= cnt_q & ~mask_q;
                    wrap_q   <= 1'b1;
                end
                OP_CINC: begin
                    cnt_q  <= inc_nxt;
                    wrap_q <= ~inc_full;
                end
                OP_MLOAD: begin
                    mask_q <= addr_in;
                    wrap_q <= 1'b1;
                end
                OP_MSET: begin
                    mask_q <= '1;
                    wrap_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign addr_out = cnt_q;
    assign wrap_n   = wrap_q;
endmodule

// File: rtl/mbc_chk.sv
// Checker for the masked burst address counter, bound to the top module.
// Assumes: mask_q is the top's internal mask register.
module mbc_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          mrst_n,
    input logic          sel_cnt,
    input logic          crst_n,
    input logic          strobe_n,
    input logic          cnten_n,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] addr_out,
    input logic [AW-1:0] mask_q,
    input logic          rb_valid,
    input logic          dq_off,
    input logic          wrap_n
);
    logic is_load, is_clr, is_inc, is_hold, is_rb;
    assign is_load = sel_cnt && crst_n && !strobe_n && !cnten_n;
    assign is_clr  = sel_cnt && !crst_n;
    assign is_inc  = sel_cnt && crst_n && strobe_n && !cnten_n;
    assign is_hold = sel_cnt && crst_n && strobe_n && cnten_n;
    assign is_rb   = crst_n && !strobe_n && cnten_n;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!mrst_n)
        $rose(mrst_n) |-> (addr_out == '0 && mask_q == '1 && wrap_n && !rb_valid)); // R1
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!mrst_n)
        is_load |=> (addr_out == $past(addr_in) && wrap_n)); // R2
    AST_CLEAR_FIELD: assert property (@(posedge clk) disable iff (!mrst_n)
        is_clr |=> ((addr_out & $past(mask_q)) == '0 && wrap_n)); // R3
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!mrst_n)
        (is_inc && ((addr_out & mask_q) != mask_q))
        |=> (((addr_out ^ $past(addr_out)) & ~$past(mask_q)) == '0)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!mrst_n)
        is_hold |=> ($stable(addr_out) && $stable(wrap_n) && $stable(mask_q))); // R8
    AST_RB_VALID: assert property (@(posedge clk) disable iff (!mrst_n)
        is_rb |=> rb_valid); // R10
    AST_RB_DQOFF: assert property (@(posedge clk) disable iff (!mrst_n)
        rb_valid |-> $past(dq_off)); // R10
endmodule

bind masked_burst_addr_gen mbc_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .sel_cnt (sel_cnt),
    .crst_n  (crst_n),
    .strobe_n(strobe_n),
    .cnten_n (cnten_n),
    .addr_in (addr_in),
    .addr_out(addr_out),
    .mask_q  (mask_q),
    .rb_valid(rb_valid),
    .dq_off  (dq_off),
    .wrap_n  (wrap_n)
);

// File: tb/tb_masked_burst_addr_gen.sv
// Bench: behavioural reference model compared on every clock.
module tb_masked_burst_addr_gen;
    localparam int AW = 18;
    localparam logic [AW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0, sel_cnt = 1'b1, crst_n = 1'b1;
    logic          strobe_n = 1'b1, cnten_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out, rb_data;
    logic          rb_valid, dq_off, wrap_n;

    int checks = 0, errors = 0;
    logic [AW-1:0] m_cnt = '0, m_mask = '1, m_mir = '0, m_rbd = '0;
    logic          m_wrap = 1'b1, m_rbv = 1'b0;
    logic [31:0]   lfsr = 32'h1234_5678;

    masked_burst_addr_gen #(.AW(AW)) dut (
        .clk(clk), .mrst_n(mrst_n), .sel_cnt(sel_cnt), .crst_n(crst_n),
        .strobe_n(strobe_n), .cnten_n(cnten_n), .addr_in(addr_in),
        .addr_out(addr_out), .rb_data(rb_data), .rb_valid(rb_valid),
        .dq_off(dq_off), .wrap_n(wrap_n)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic field_full(input logic [AW-1:0] c, input logic [AW-1:0] m);
        for (int i = 0; i < AW; i++) if (m[i] && !c[i]) return 1'b0;
        return 1'b1;
    endfunction

    // Count the unmasked bits as a packed integer and add one.
    function automatic logic [AW-1:0] model_inc(input logic [AW-1:0] c,
            input logic [AW-1:0] m, input logic [AW-1:0] mir);
        logic [AW-1:0] r = c;
        longint f = 0;
        int n = 0;
        for (int i = 0; i < AW; i++) if (m[i]) begin
            if (c[i]) f = f + (longint'(1) << n);
            n++;
        end
        if (f == (longint'(1) << n) - 1) return mir;
        f = f + 1;
        n = 0;
        for (int i = 0; i < AW; i++) if (m[i]) begin
            r[i] = f[n];
            n++;
        end
        return r;
    endfunction

    task automatic step(input logic mr, input logic s, input logic cr,
            input logic st, input logic en, input logic [AW-1:0] a, input string req);
        logic rbq;
        mrst_n = mr; sel_cnt = s; crst_n = cr; strobe_n = st; cnten_n = en; addr_in = a;
        rbq = mr && cr && !st && en;
        #1;
        chk({req, " R10 dq_off"}, AW'(dq_off), AW'(rbq));
        @(posedge clk);
        if (!mr) begin
            m_cnt = '0; m_mir = '0; m_mask = '1; m_wrap = 1'b1; m_rbv = 1'b0; m_rbd = '0;
        end else begin
            m_rbv = rbq;
            m_rbd = rbq ? (s ? m_cnt : m_mask) : '0;
            if (s) begin
                if (!cr) begin
                    m_cnt = m_cnt & ~m_mask; m_mir = m_cnt; m_wrap = 1'b1;
                end else if (!st && !en) begin
                    m_cnt = a; m_mir = a; m_wrap = 1'b1;
                end else if (st && !en) begin
                    m_cnt = model_inc(m_cnt, m_mask, m_mir);
                    m_wrap = !field_full(m_cnt, m_mask);
                end
            end else begin
                if (!cr) begin
                    m_mask = '1; m_wrap = 1'b1;
                end else if (!st && !en) begin
                    m_mask = a; m_wrap = 1'b1;
                end
            end
        end
        @(negedge clk);
        chk({req, " addr_out"}, addr_out, m_cnt);
        chk({req, " wrap_n"}, AW'(wrap_n), AW'(m_wrap));
        chk({req, " R10 rb_valid"}, AW'(rb_valid), AW'(m_rbv));
        if (m_rbv) chk({req, " R10 rb_data"}, rb_data, m_rbd);
    endtask

    task automatic cload(input logic [AW-1:0] a, input string r); step(1,1,1,0,0,a,r); endtask
    task automatic mload(input logic [AW-1:0] a, input string r); step(1,0,1,0,0,a,r); endtask
    task automatic cinc(input string r);  step(1,1,1,1,0,'0,r); endtask
    task automatic crb(input string r);   step(1,1,1,0,1,'0,r); endtask
    task automatic mrb(input string r);   step(1,0,1,0,1,'0,r); endtask

    initial begin
        step(0,1,1,0,0,18'h2AAAA,"R1 reset with load code");
        step(0,0,0,1,0,'0,"R1 reset with mask code");
        mrb("R1 mask all ones");
        chk("R1 mask readback", rb_data, ONES);
        chk("R1 counter zero", addr_out, '0);
        // Contiguous six-bit field under a fixed base.
        mload(18'h0003F, "R9 mask load");
        cload(18'h12348, "R2 counter load");
        chk("R2 load value", addr_out, 18'h12348);
        for (int i = 0; i < 55; i++) cinc("R4 R5 increment");
        chk("R5 flag low at all ones", AW'(wrap_n), '0);
        chk("R5 field full", addr_out, 18'h1237F);
        step(1,1,1,1,1,'0,"R8 hold");
        step(1,0,1,1,0,'0,"R8 reserved code");
        step(1,0,1,1,1,'0,"R8 reserved code");
        chk("R8 flag kept", AW'(wrap_n), '0);
        cinc("R6 wrap to mirror");
        chk("R6 mirror value", addr_out, 18'h12348);
        chk("R5 flag released", AW'(wrap_n), 18'h1);
        // Flag release by each clearing operation.
        cload(18'h0003E, "R2 load"); cinc("R5 inc");
        chk("R5 flag low", AW'(wrap_n), '0);
        cload(18'h00010, "R7 load releases");
        cload(18'h0003E, "R2 load"); cinc("R5 inc");
        mload(18'h0003F, "R7 mask load releases");
        cinc("R6 inc"); step(1,0,0,1,1,'0,"R7 mask reset releases");
        cload(18'h12375, "R2 load"); mload(18'h0003F, "R9 mask load");
        step(1,1,0,1,1,'0,"R3 counter reset");
        chk("R3 cleared field", addr_out, 18'h12340);
        cinc("R4 inc after clear"); cinc("R4 inc");
        // Bit 0 masked: step of two.
        mload(18'h0003E, "R9 mask load");
        cload(18'h00101, "R2 load");
        cinc("R4 step two");
        chk("R4 step two value", addr_out, 18'h00103);
        for (int i = 0; i < 34; i++) cinc("R4 R6 step two run");
        // Split field and empty field.
        mload(18'h0F0F0, "R9 mask load");
        cload(18'h20F0F, "R2 load");
        for (int i = 0; i < 40; i++) cinc("R4 split field");
        crb("R10 counter readback");
        mrb("R10 mask readback");
        chk("R10 mask value", rb_data, 18'h0F0F0);
        mload('0, "R9 empty mask");
        cinc("R6 empty field");
        chk("R6 empty field stays", addr_out, 18'h20F0F);
        // Pseudo-random sequences over all codes.
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step((lfsr[7:0] != 8'h00), lfsr[9], (lfsr[12:10] != 3'b000), lfsr[13],
                 lfsr[14], (lfsr[15] ? AW'(lfsr[31:14]) : AW'(lfsr[5:0])), "R1-mix random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule